// File: doc/BRIEF.md
# Audio Mute and Soft-Start Sequencer

This block handles pop and click suppression for a stereo digital audio path. A control state machine watches a clock-valid flag and a one-cycle clock-loss pulse. It produces two control values: a digital code for the DC bias level, and a gain coefficient that it applies to the left and right two's complement samples on every sample strobe. After reset the bias code stays at ground. When the clock first becomes valid, the code climbs linearly to the quiescent level. If the clock drops out during this climb, the code freezes in place. Once the code reaches the quiescent level, the audio gain rises from zero to unity over a fixed number of samples. Because the rise is counted in samples, its length in time follows the sample rate.

A clock fault while audio is audible cuts the output to exactly zero around the quiescent level in the next cycle, with no fade. While the block is muted, the return of a valid clock starts a new gain rise from zero. The `state_o` output reports the current state: GROUND=0, DC_RAMP=1, DC_HOLD=2, SOFT=3, RUN=4, MUTE=5. The transitions are as follows. GROUND goes to DC_RAMP when the clock is valid. DC_RAMP goes to DC_HOLD on a fault and to SOFT when the code reaches the quiescent value. DC_HOLD goes back to DC_RAMP when the fault clears. SOFT goes to RUN at full gain. Both SOFT and RUN go to MUTE on a fault. MUTE goes to SOFT when the fault clears. A fault means `clk_ok` is low or `clk_lost` is high.

Top module: `pop_guard_seq`

## Requirements
- R1: After reset, `state_o` is 0 (GROUND), and `dc_code`, `gain`, `left_out` and `right_out` are all 0. This holds while `clk_ok` is low, and sample strobes have no effect in this state.
- R2: With `clk_ok` high, the state becomes 1 (DC_RAMP). `dc_code` then rises by 64 once every `dc_div`+1 cycles. The final step is clamped at the quiescent code 31457, and the code never decreases.
- R3: A fault during DC_RAMP moves the state to 2 (DC_HOLD) and `dc_code` stays unchanged. When `clk_ok` returns, the state goes back to 1 and the ramp continues from the held code.
- R4: When `dc_code` reaches 31457, the state becomes 3 (SOFT) with `gain` = 0. After k sample strobes, `gain` equals floor(k·32768/960). After 960 strobes `gain` is 32768 and the state becomes 4 (RUN), where `gain` stays at 32768.
- R5: On each `smp_stb` in SOFT or RUN, each output becomes floor(input·gain / 2^15), clamped to the signed 24-bit range. The gain used is the value held before that strobe. In RUN the output therefore equals the input.
- R6: In SOFT or RUN, a cycle without a strobe and without a fault leaves both outputs unchanged, even when the inputs change.
- R7: A fault in SOFT or RUN gives state 5 (MUTE) in the next cycle. In that same cycle `gain` and both outputs are 0, and `dc_code` stays at 31457.
- R8: In MUTE, both outputs stay 0 whatever the sample strobes and input values.
- R9: In MUTE, a cycle with `clk_ok` high and `clk_lost` low leads to state 3 with `gain` = 0. A new rise then starts, and the first strobe brings `gain` to 34.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous power-on reset |
| clk_ok | input | 1 | High while a valid clock ratio is present |
| clk_lost | input | 1 | One-cycle pulse on a loss-of-clock event |
| smp_stb | input | 1 | One-cycle strobe per stereo sample period |
| dc_div | input | 12 | DC ramp steps once every dc_div+1 cycles |
| left_in | input | 24 | Left two's complement input sample |
| right_in | input | 24 | Right two's complement input sample |
| dc_code | output | 16 | Digital DC bias level code |
| gain | output | 16 | Unsigned gain coefficient, 32768 = unity |
| left_out | output | 24 | Left scaled sample |
| right_out | output | 24 | Right scaled sample |
| state_o | output | 3 | Current sequencer state |

## Verification
The assertions assume that `rst_n` is driven low from time zero. They also assume that `clk_lost` and `smp_stb` are one-cycle pulses driven away from the clock edge, and that `dc_div` does not change while the DC ramp is running. The stimulus changes every input on the falling edge only. It sets `dc_div` once, before `clk_ok` first rises, and never asserts `clk_lost` for more than one cycle. It drops `clk_ok` only at defined points in each scenario, so the hold, mute and restart transitions each happen at a known cycle.

// File: rtl/pop_guard_pkg.sv
package pop_guard_pkg;

    typedef enum logic [2:0] {
        PG_GROUND  = 3'd0,
        PG_DC_RAMP = 3'd1,
        PG_DC_HOLD = 3'd2,
        PG_SOFT    = 3'd3,
        PG_RUN     = 3'd4,
        PG_MUTE    = 3'd5
    } pg_state_e;

    // audio may pass only in these two states
    function automatic logic pg_audible(input pg_state_e s);
        return (s == PG_SOFT) || (s == PG_RUN);
    endfunction

endpackage

// File: rtl/pop_guard_dc_ramp.sv
module pop_guard_dc_ramp #(
    parameter int unsigned DC_W     = 16,
    parameter int unsigned DIV_W    = 12,
    parameter int unsigned DC_QUIET = 31457,
    parameter int unsigned DC_STEP  = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_en,
    input  logic [DIV_W-1:0] dc_div,
    output logic [DC_W-1:0]  dc_code,
    output logic             dc_done
);

    localparam logic [DC_W:0] QUIET_X = (DC_W+1)'(DC_QUIET);
    localparam logic [DC_W:0] STEP_X  = (DC_W+1)'(DC_STEP);

    logic [DIV_W-1:0] tick_q;
    logic [DC_W-1:0]  lvl_q;
    logic [DC_W:0]    lvl_sum;

    assign lvl_sum = {1'b0, lvl_q} + STEP_X;
    assign dc_done = ({1'b0, lvl_q} == QUIET_X);
    assign dc_code = lvl_q;

    // divider and level both freeze whenever run_en is low
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tick_q <= '0;
            lvl_q  <= '0;
        end else if (run_en && !dc_done) begin
            if (tick_q >= dc_div) begin
                tick_q <= '0;
                lvl_q  <= (lvl_sum >= QUIET_X) ? QUIET_X[DC_W-1:0] : lvl_sum[DC_W-1:0];
            end else begin
                tick_q <= tick_q + DIV_W'(1);
            end
        end
    end

endmodule

// File: rtl/pop_guard_gain_ramp.sv
module pop_guard_gain_ramp #(
    parameter int unsigned GAIN_W    = 16,
    parameter int unsigned FULL_GAIN = 32768,
    parameter int unsigned RAMP_LEN  = 960
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              step,
    output logic [GAIN_W-1:0] gain,
    output logic              gain_full
);

    localparam int unsigned QUO   = FULL_GAIN / RAMP_LEN;
    localparam int unsigned REM   = FULL_GAIN % RAMP_LEN;
    localparam int unsigned ACC_W = $clog2(RAMP_LEN) + 1;

    localparam logic [ACC_W-1:0]  REM_X  = ACC_W'(REM);
    localparam logic [ACC_W-1:0]  LEN_X  = ACC_W'(RAMP_LEN);
    localparam logic [GAIN_W:0]   QUO_X  = (GAIN_W+1)'(QUO);
    localparam logic [GAIN_W:0]   FULL_X = (GAIN_W+1)'(FULL_GAIN);

    logic [GAIN_W-1:0] gain_q;
    logic [ACC_W-1:0]  acc_q;
    logic [ACC_W-1:0]  acc_sum;
    logic              carry;
    logic [GAIN_W:0]   g_next;

    // remainder carry keeps gain at floor(k*FULL/LEN) exactly
    assign acc_sum   = acc_q + REM_X;
    assign carry     = (acc_sum >= LEN_X);
    assign g_next    = {1'b0, gain_q} + QUO_X + (GAIN_W+1)'(carry);
    assign gain_full = ({1'b0, gain_q} == FULL_X);
    assign gain      = gain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gain_q <= '0;
            acc_q  <= '0;
        end else if (clr) begin
            gain_q <= '0;
            acc_q  <= '0;
        end else if (step && !gain_full) begin
            gain_q <= (g_next >= FULL_X) ? FULL_X[GAIN_W-1:0] : g_next[GAIN_W-1:0];
            acc_q  <= carry ? (acc_sum - LEN_X) : acc_sum;
        end
    end

endmodule

// File: rtl/pop_guard_scale.sv
module pop_guard_scale #(
    parameter int unsigned SMP_W  = 24,
    parameter int unsigned GAIN_W = 16,
    parameter int unsigned FRAC   = 15
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    stb,
    input  logic                    zero,
    input  logic signed [SMP_W-1:0] smp_in,
    input  logic [GAIN_W-1:0]       gain,
    output logic signed [SMP_W-1:0] smp_out
);

    localparam int unsigned PROD_W = SMP_W + GAIN_W + 1;

    localparam logic signed [PROD_W-1:0] HI_X =
        {{(PROD_W-SMP_W+1){1'b0}}, {(SMP_W-1){1'b1}}};
    localparam logic signed [PROD_W-1:0] LO_X =
        {{(PROD_W-SMP_W+1){1'b1}}, {(SMP_W-1){1'b0}}};

    logic signed [PROD_W-1:0] prod;
    logic signed [PROD_W-1:0] shifted;
    logic signed [SMP_W-1:0]  sat_v;

    assign prod    = PROD_W'(smp_in) * PROD_W'($signed({1'b0, gain}));
    assign shifted = prod >>> FRAC;

    always_comb begin
        if (shifted > HI_X) begin
            sat_v = HI_X[SMP_W-1:0];
        end else if (shifted < LO_X) begin
            sat_v = LO_X[SMP_W-1:0];
        end else begin
            sat_v = shifted[SMP_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            smp_out <= '0;
        end else if (zero) begin
            smp_out <= '0;
        end else if (stb) begin
            smp_out <= sat_v;
        end
    end

endmodule

// File: rtl/pop_guard_seq.sv
module pop_guard_seq
    import pop_guard_pkg::*;
#(
    parameter int unsigned SMP_W     = 24,
    parameter int unsigned GAIN_W    = 16,
    parameter int unsigned FRAC      = 15,
    parameter int unsigned FULL_GAIN = 32768,
    parameter int unsigned RAMP_LEN  = 960,
    parameter int unsigned DC_W      = 16,
    parameter int unsigned DIV_W     = 12,
    parameter int unsigned DC_QUIET  = 31457,
    parameter int unsigned DC_STEP   = 64
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clk_ok,
    input  logic                    clk_lost,
    input  logic                    smp_stb,
    input  logic [DIV_W-1:0]        dc_div,
    input  logic signed [SMP_W-1:0] left_in,
    input  logic signed [SMP_W-1:0] right_in,
    output logic [DC_W-1:0]         dc_code,
    output logic [GAIN_W-1:0]       gain,
    output logic signed [SMP_W-1:0] left_out,
    output logic signed [SMP_W-1:0] right_out,
    output logic [2:0]              state_o
);

    localparam int unsigned CHANNELS = 2;

    pg_state_e state_q;
    pg_state_e state_d;

    logic fault;
    logic dc_done;
    logic gain_full;
    logic ramp_run;
    logic gain_clr;
    logic gain_step;
    logic out_zero;

    logic signed [SMP_W-1:0] ch_in  [CHANNELS];
    logic signed [SMP_W-1:0] ch_out [CHANNELS];

    assign fault = clk_lost || !clk_ok;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PG_GROUND;
        end else begin
            state_q <= state_d;
        end
    end

    // next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PG_GROUND:  if (!fault) state_d = PG_DC_RAMP;
            PG_DC_RAMP: begin
                if (fault) begin
                    state_d = PG_DC_HOLD;
                end else if (dc_done) begin
                    state_d = PG_SOFT;
                end
            end
            PG_DC_HOLD: if (!fault) state_d = PG_DC_RAMP;
            PG_SOFT: begin
                if (fault) begin
                    state_d = PG_MUTE;
                end else if (gain_full) begin
                    state_d = PG_RUN;
                end
            end
            PG_RUN:     if (fault) state_d = PG_MUTE;
            PG_MUTE:    if (!fault) state_d = PG_SOFT;
            default:    state_d = PG_GROUND;
        endcase
    end

    // control outputs
    always_comb begin
        ramp_run  = (state_q == PG_DC_RAMP) && !fault;
        gain_clr  = !pg_audible(state_d);
        gain_step = (state_q == PG_SOFT) && smp_stb && !fault;
        out_zero  = !pg_audible(state_d);
    end

    pop_guard_dc_ramp #(
        .DC_W     (DC_W),
        .DIV_W    (DIV_W),
        .DC_QUIET (DC_QUIET),
        .DC_STEP  (DC_STEP)
    ) u_dc (
        .clk     (clk),
        .rst_n   (rst_n),
        .run_en  (ramp_run),
        .dc_div  (dc_div),
        .dc_code (dc_code),
        .dc_done (dc_done)
    );

    pop_guard_gain_ramp #(
        .GAIN_W    (GAIN_W),
        .FULL_GAIN (FULL_GAIN),
        .RAMP_LEN  (RAMP_LEN)
    ) u_gain (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (gain_clr),
        .step      (gain_step),
        .gain      (gain),
        .gain_full (gain_full)
    );

    assign ch_in[0] = left_in;
    assign ch_in[1] = right_in;

    for (genvar c = 0; c < CHANNELS; c++) begin : g_ch
        pop_guard_scale #(
            .SMP_W  (SMP_W),
            .GAIN_W (GAIN_W),
            .FRAC   (FRAC)
        ) u_scale (
            .clk     (clk),
            .rst_n   (rst_n),
            .stb     (smp_stb),
            .zero    (out_zero),
            .smp_in  (ch_in[c]),
            .gain    (gain),
            .smp_out (ch_out[c])
        );
    end

    assign left_out  = ch_out[0];
    assign right_out = ch_out[1];
    assign state_o   = state_q;

endmodule

// File: rtl/pop_guard_chk.sv
module pop_guard_chk
    import pop_guard_pkg::*;
#(
    parameter int unsigned SMP_W     = 24,
    parameter int unsigned GAIN_W    = 16,
    parameter int unsigned FULL_GAIN = 32768,
    parameter int unsigned DC_W      = 16,
    parameter int unsigned DC_QUIET  = 31457
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    clk_ok,
    input logic                    clk_lost,
    input logic                    smp_stb,
    input logic [2:0]              state_q,
    input logic [DC_W-1:0]         dc_code,
    input logic [GAIN_W-1:0]       gain,
    input logic signed [SMP_W-1:0] left_out,
    input logic signed [SMP_W-1:0] right_out
);

    localparam logic [GAIN_W-1:0] FULL_X  = GAIN_W'(FULL_GAIN);
    localparam logic [DC_W-1:0]   QUIET_X = DC_W'(DC_QUIET);

    logic past_ok;
    logic audible;
    logic flt;

    assign audible = (state_q == PG_SOFT) || (state_q == PG_RUN);
    assign flt     = clk_lost || !clk_ok;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            past_ok <= 1'b0;
        end else begin
            past_ok <= 1'b1;
        end
    end

    // R1
    pre_audio_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PG_GROUND || state_q == PG_DC_RAMP || state_q == PG_DC_HOLD)
        |-> (gain == '0 && left_out == '0 && right_out == '0));

    // R2
    dc_monotonic_chk: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> (dc_code >= $past(dc_code)));

    // R2
    dc_ceiling_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dc_code <= QUIET_X);

    // R3
    hold_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PG_DC_HOLD) |=> $stable(dc_code));

    // R4
    run_full_gain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PG_RUN) |-> (gain == FULL_X));

    // R4
    gain_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gain <= FULL_X);

    // R6
    idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (audible && !smp_stb && !flt) |=> ($stable(left_out) && $stable(right_out)));

    // R7
    fault_mutes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (audible && flt) |=> (state_q == PG_MUTE && gain == '0
                              && left_out == '0 && right_out == '0));

    // R8
    mute_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PG_MUTE) |-> (left_out == '0 && right_out == '0 && dc_code == QUIET_X));

    // R9
    mute_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PG_MUTE && !flt) |=> (state_q == PG_SOFT && gain == '0));

endmodule

bind pop_guard_seq pop_guard_chk #(
    .SMP_W     (SMP_W),
    .GAIN_W    (GAIN_W),
    .FULL_GAIN (FULL_GAIN),
    .DC_W      (DC_W),
    .DC_QUIET  (DC_QUIET)
) u_pg_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .clk_ok    (clk_ok),
    .clk_lost  (clk_lost),
    .smp_stb   (smp_stb),
    .state_q   (state_q),
    .dc_code   (dc_code),
    .gain      (gain),
    .left_out  (left_out),
    .right_out (right_out)
);

// File: tb/pop_guard_seq_test.sv
module pop_guard_seq_test;

    localparam int CLK_PERIOD = 10;
    localparam longint QUIET  = 31457;
    localparam longint FULL   = 32768;
    localparam int     LEN    = 960;

    logic clk;
    logic rst_n;
    logic clk_ok;
    logic clk_lost;
    logic smp_stb;
    logic [11:0] dc_div;
    logic signed [23:0] left_in;
    logic signed [23:0] right_in;
    logic [15:0] dc_code;
    logic [15:0] gain;
    logic signed [23:0] left_out;
    logic signed [23:0] right_out;
    logic [2:0] state_o;

    int checks = 0;
    int errors = 0;

    pop_guard_seq uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .clk_ok    (clk_ok),
        .clk_lost  (clk_lost),
        .smp_stb   (smp_stb),
        .dc_div    (dc_div),
        .left_in   (left_in),
        .right_in  (right_in),
        .dc_code   (dc_code),
        .gain      (gain),
        .left_out  (left_out),
        .right_out (right_out),
        .state_o   (state_o)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic longint scale_exp(input longint s, input longint g);
        longint p;
        p = (s * g) >>> 15;
        if (p > 8388607) p = 8388607;
        if (p < -8388608) p = -8388608;
        return p;
    endfunction

    task automatic after_edge();
        @(posedge clk);
        #1;
    endtask

    // one strobe; returns after the capturing edge
    task automatic strobe(input longint l, input longint r);
        @(negedge clk);
        smp_stb  = 1'b1;
        left_in  = 24'(l);
        right_in = 24'(r);
        after_edge();
        @(negedge clk);
        smp_stb = 1'b0;
    endtask

    task automatic t_reset();
        repeat (10) after_edge();
        check(state_o == 3'd0, "R1 state after reset", state_o, 0);
        check(dc_code == 16'd0, "R1 dc_code after reset", dc_code, 0);
        check(gain == 16'd0, "R1 gain after reset", gain, 0);
        strobe(1234567, -7654321);
        #1;
        check(left_out == 0 && right_out == 0, "R1 strobe ignored in ground",
              longint'(left_out), 0);
        check(state_o == 3'd0, "R1 stays ground while clock invalid", state_o, 0);
    endtask

    task automatic t_dc_ramp();
        longint prev;
        longint step_exp;
        int since;
        int nsteps;
        int bad_step;
        int bad_int;
        bit skip_int;
        bit held;
        longint held_val;
        @(negedge clk);
        dc_div = 12'd3;
        clk_ok = 1'b1;
        after_edge();
        check(state_o == 3'd1, "R2 enters DC ramp", state_o, 1);
        prev = 0; since = 0; nsteps = 0; bad_step = 0; bad_int = 0;
        skip_int = 0; held = 0; held_val = 0;
        for (int n = 0; n < 6000; n++) begin
            after_edge();
            if (state_o != 3'd1) break;
            since++;
            if (longint'(dc_code) != prev) begin
                step_exp = (QUIET - prev < 64) ? (QUIET - prev) : 64;
                if (longint'(dc_code) - prev != step_exp) bad_step++;
                if (!skip_int && since != 4) bad_int++;
                skip_int = 0;
                prev = dc_code;
                since = 0;
                nsteps++;
                if (nsteps == 100 && !held) begin
                    held = 1;
                    @(negedge clk);
                    clk_ok = 1'b0;
                    after_edge();
                    check(state_o == 3'd2, "R3 enters DC hold", state_o, 2);
                    held_val = dc_code;
                    check(held_val == 6400, "R3 held level", held_val, 6400);
                    for (int h = 0; h < 40; h++) begin
                        after_edge();
                        if (longint'(dc_code) != held_val) bad_step++;
                    end
                    check(longint'(dc_code) == held_val, "R3 level frozen in hold",
                          dc_code, held_val);
                    @(negedge clk);
                    clk_ok = 1'b1;
                    after_edge();
                    check(state_o == 3'd1, "R3 ramp resumes", state_o, 1);
                    skip_int = 1;
                    since = 0;
                end
            end
        end
        check(bad_step == 0, "R2 step size", bad_step, 0);
        check(bad_int == 0, "R2 step interval", bad_int, 0);
        check(longint'(dc_code) == QUIET, "R2 reaches quiescent code", dc_code, QUIET);
        check(state_o == 3'd3, "R4 enters soft start", state_o, 3);
        check(gain == 16'd0, "R4 soft start begins at zero", gain, 0);
    endtask

    task automatic t_soft_start();
        longint g_exp;
        longint l;
        longint r;
        int bad_gain;
        int bad_out;
        int bad_idle;
        bad_gain = 0; bad_out = 0; bad_idle = 0;
        for (int k = 0; k < LEN; k++) begin
            g_exp = (longint'(k) * FULL) / LEN;
            if (longint'(gain) != g_exp) begin
                bad_gain++;
                if (bad_gain == 1) check(0, "R4 gain profile", gain, g_exp);
            end
            l = longint'(k) * 8737 - 4000000;
            r = 3000000 - longint'(k) * 6151;
            strobe(l, r);
            #1;
            if (longint'(left_out) != scale_exp(l, g_exp) ||
                longint'(right_out) != scale_exp(r, g_exp)) begin
                bad_out++;
                if (bad_out == 1) check(0, "R5 scaled sample in soft start",
                                         left_out, scale_exp(l, g_exp));
            end
            left_in = 24'(l + 99);
            after_edge();
            if (k < LEN - 1 && longint'(left_out) != scale_exp(l, g_exp)) bad_idle++;
        end
        check(bad_gain == 0, "R4 gain follows floor(k*32768/960)", bad_gain, 0);
        check(bad_out == 0, "R5 outputs scaled during soft start", bad_out, 0);
        check(bad_idle == 0, "R6 outputs hold between strobes", bad_idle, 0);
        check(gain == 16'd32768, "R4 full gain after 960 strobes", gain, FULL);
        check(state_o == 3'd4, "R4 enters run", state_o, 4);
    endtask

    task automatic t_run();
        strobe(8388607, -8388608);
        #1;
        check(left_out == 24'sd8388607, "R5 unity gain positive full scale", left_out, 8388607);
        check(right_out == -24'sd8388608, "R5 unity gain negative full scale", right_out, -8388608);
        strobe(-1, 1);
        #1;
        check(left_out == -24'sd1 && right_out == 24'sd1, "R5 unity gain small values",
              left_out, -1);
        @(negedge clk);
        left_in  = 24'sd5555;
        right_in = -24'sd5555;
        repeat (3) after_edge();
        check(left_out == -24'sd1, "R6 no strobe keeps output", left_out, -1);
        check(gain == 16'd32768, "R4 gain stays full in run", gain, FULL);
    endtask

    task automatic t_fault_run();
        @(negedge clk);
        clk_ok = 1'b0;
        after_edge();
        check(state_o == 3'd5, "R7 clock invalid mutes", state_o, 5);
        check(gain == 16'd0, "R7 gain cleared on mute", gain, 0);
        check(left_out == 0 && right_out == 0, "R7 outputs zero at once", left_out, 0);
        check(longint'(dc_code) == QUIET, "R7 dc stays quiescent", dc_code, QUIET);
        strobe(4000000, -4000000);
        strobe(-8388608, 8388607);
        #1;
        check(left_out == 0 && right_out == 0, "R8 strobes ignored in mute", left_out, 0);
        check(state_o == 3'd5, "R8 remains muted while invalid", state_o, 5);
        @(negedge clk);
        clk_ok = 1'b1;
        after_edge();
        check(state_o == 3'd3, "R9 valid clock restarts soft start", state_o, 3);
        check(gain == 16'd0, "R9 restart from zero gain", gain, 0);
        strobe(2000000, 2000000);
        #1;
        check(left_out == 0, "R5 first restart sample uses zero gain", left_out, 0);
        check(gain == 16'd34, "R9 first restart step", gain, 34);
    endtask

    task automatic t_lost_in_soft();
        for (int k = 0; k < 5; k++) strobe(1000000, -1000000);
        #1;
        check(gain == 16'd204, "R4 gain after six restart strobes", gain, 204);
        check(longint'(left_out) == scale_exp(1000000, 170), "R5 restart scaled sample",
              left_out, scale_exp(1000000, 170));
        @(negedge clk);
        clk_lost = 1'b1;
        after_edge();
        check(state_o == 3'd5, "R7 loss pulse mutes soft start", state_o, 5);
        check(left_out == 0 && right_out == 0, "R7 loss pulse zeroes outputs", left_out, 0);
        @(negedge clk);
        clk_lost = 1'b0;
        after_edge();
        check(state_o == 3'd3, "R9 leaves mute after pulse", state_o, 3);
        check(gain == 16'd0, "R9 fresh ramp after pulse", gain, 0);
    endtask

    bit finished = 0;

    initial begin
        rst_n = 1'b0; clk_ok = 1'b0; clk_lost = 1'b0; smp_stb = 1'b0;
        dc_div = 12'd0; left_in = '0; right_in = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_dc_ramp();
        t_soft_start();
        t_run();
        t_fault_run();
        t_lost_in_soft();
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog run incomplete actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule